// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

This block receives asynchronous serial frames on a single line, RX. A one-cycle enable pulse, `tick_i`, arrives sixteen times per bit period. The receiver finds each start bit, samples every later bit in the middle of its period and shifts in eight data bits, least significant bit first. It can then check a parity bit, even or odd. It checks the first stop bit. When configured for two stop bits, it waits out the second one without judging it.

Each finished frame is written to a data register, and a ready flag tells software that a byte is waiting. Three error flags record problems: overrun, framing and parity. They are sticky. Software clears an error flag only by reading the status as 1 and then writing 0 to that bit. While an overrun or a framing error is pending, the receiver does not start a new frame. A standby input returns all flags to zero and abandons any frame in progress.

The receive path is a state machine with six states:
- IDLE waits for a high-to-low edge on the line.
- START confirms the start bit at half a bit period. If the line is high there, it returns to IDLE as a glitch.
- DATA shifts in the data bits. After the last one it goes to PARITY when parity is enabled, and to STOP1 otherwise.
- PARITY samples the parity bit and moves on to STOP1.
- STOP1 samples the checked stop bit and ends the frame. It goes to STOP2 when two stop bits are configured, and to IDLE otherwise.
- STOP2 waits one bit period and returns to IDLE.

From every state, standby or a low receive-enable forces a return to IDLE.

Top module: `sticky_uart_rx`

## Requirements
- R1: After reset, a status read returns 0x00 and a data read returns 0x00. The register map is as follows:
  - Address 0 is status: bit0 ready, bit1 overrun, bit2 framing, bit3 parity.
  - Address 1 is data.
- R2: A start is taken only on a high-to-low edge seen while idle, and only if the line is still low 8 ticks later. A shorter low pulse produces no frame.
- R3: Data bits are sampled every 16 ticks, least significant bit first. A good frame loads the data register and sets ready. A data read clears ready.
- R4: With parity enabled, the parity flag sets when the parity bit does not match the configured sense. With even parity the total count of ones is even; with odd parity it is odd. The data is still loaded and ready still set.
- R5: A checked stop bit sampled as 0 sets the framing flag. It loads the data register and leaves ready at 0.
- R6: When two stop bits are configured, the second stop bit is never checked.
- R7: A frame that finishes while ready is 1 sets the overrun flag. That frame is discarded and the data register keeps the earlier byte.
- R8: While the overrun or framing flag is 1, no new frame is received. Reception resumes once both are cleared.
- R9: An error flag clears only on a write of 0 to its bit after a status read that returned it as 1. Each flag is armed on its own, and any status write disarms it. A write of 0 without such a read, or a write of 1, has no effect.
- R10: Reading the data register does not clear any error flag.
- R11: While receive-enable is low, no frame is received. The error flags keep their values.
- R12: Standby clears ready and all error flags.
- R13: A frame with both a bad parity bit and a bad stop bit sets both the framing and the parity flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby entry; clears flags and aborts reception |
| rx_en_i | input | 1 | Receive enable |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| rx_i | input | 1 | Serial line, idle high |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| two_stop_i | input | 1 | Frame carries two stop bits |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = status, 1 = data |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while a read is strobed |

## Verification
A wrong internal state shows at the status register within the frame in which it matters. Three failures can be seen when the next status read follows the checked stop bit:
- A bit counter off by one gives a shifted byte.
- A mis-sampled stop bit raises or hides the framing flag.
- A stuck arm bit lets a blind write of 0 clear a flag, or stops a proper read-then-write clear from working.

A freeze that fails to hold shows up as a changed data byte or a raised ready flag after a frame sent while an error is pending. The directed scenarios place a status or data read after every frame, so each such fault surfaces before the next scenario begins.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    localparam int NUM_ERR   = 3;
    localparam int ERR_OVR   = 0;
    localparam int ERR_FER   = 1;
    localparam int ERR_PER   = 2;
    localparam int STAT_RDY  = 0;
    localparam int STAT_ERR0 = 1;

    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rxu_frame_fsm.sv
module rxu_frame_fsm
    import rxu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              rx_en_i,
    input  logic              freeze_i,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    output logic              done_o,
    output logic              stop_bad_o,
    output logic              par_bad_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    rx_state_e         state_q;
    rx_state_e         state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_bad_q;
    logic              idle_hi_q;

    logic half_hit;
    logic full_hit;
    logic start_ok;

    assign half_hit = tick_i && (cnt_q == CNT_HALF);
    assign full_hit = tick_i && (cnt_q == CNT_FULL);
    assign start_ok = tick_i && !rx_i && idle_hi_q && !freeze_i;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (standby_i || !rx_en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) state_d = ST_START;
                end
                ST_START: begin
                    if (half_hit) state_d = rx_i ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    if (full_hit && (bit_q == BIT_LAST))
                        state_d = par_en_i ? ST_PARITY : ST_STOP1;
                end
                ST_PARITY: begin
                    if (full_hit) state_d = ST_STOP1;
                end
                ST_STOP1: begin
                    if (full_hit) state_d = two_stop_i ? ST_STOP2 : ST_IDLE;
                end
                ST_STOP2: begin
                    if (full_hit) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            par_bad_q <= 1'b0;
            idle_hi_q <= 1'b0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (tick_i)        cnt_q <= cnt_q + 1'b1;

            if (state_q == ST_START) begin
                bit_q     <= '0;
                par_bad_q <= 1'b0;
            end

            if ((state_q == ST_DATA) && full_hit) begin
                shift_q <= {rx_i, shift_q[DATA_W-1:1]};
                bit_q   <= bit_q + 1'b1;
            end

            if ((state_q == ST_PARITY) && full_hit)
                par_bad_q <= ((rx_i ^ (^shift_q)) != par_odd_i);

            if (state_q != ST_IDLE) idle_hi_q <= 1'b0;
            else if (rx_i)          idle_hi_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        done_o     = (state_q == ST_STOP1) && full_hit && rx_en_i && !standby_i;
        stop_bad_o = !rx_i;
        par_bad_o  = par_bad_q;
        busy_o     = (state_q != ST_IDLE);
        data_o     = shift_q;
    end

endmodule

// File: rtl/rxu_regs.sv
module rxu_regs
    import rxu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] frame_i,
    input  logic              stop_bad_i,
    input  logic              par_bad_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ready_o,
    output logic [NUM_ERR-1:0] err_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int PAD_W = DATA_W - 1 - NUM_ERR;

    logic              ready_q;
    logic [DATA_W-1:0] data_q;
    logic [NUM_ERR-1:0] err_q;
    logic [NUM_ERR-1:0] arm_q;
    logic [NUM_ERR-1:0] err_set;
    logic rd_stat, wr_stat, rd_data;
    logic unused_wdata;

    assign rd_stat = sel_i && !wr_i && (addr_i == ADDR_STAT);
    assign wr_stat = sel_i &&  wr_i && (addr_i == ADDR_STAT);
    assign rd_data = sel_i && !wr_i && (addr_i == ADDR_DATA);
    assign unused_wdata = ^{wdata_i[DATA_W-1:STAT_ERR0+NUM_ERR], wdata_i[STAT_RDY]};

    always_comb begin
        err_set          = '0;
        err_set[ERR_OVR] = done_i && ready_q;
        err_set[ERR_FER] = done_i && !ready_q && stop_bad_i;
        err_set[ERR_PER] = done_i && !ready_q && par_bad_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ERR; gi++) begin : g_err
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    err_q[gi] <= 1'b0;
                    arm_q[gi] <= 1'b0;
                end else if (standby_i) begin
                    err_q[gi] <= 1'b0;
                    arm_q[gi] <= 1'b0;
                end else begin
                    if (err_set[gi])
                        err_q[gi] <= 1'b1;
                    else if (wr_stat && arm_q[gi] && !wdata_i[STAT_ERR0+gi])
                        err_q[gi] <= 1'b0;

                    if (wr_stat)                   arm_q[gi] <= 1'b0;
                    else if (rd_stat && err_q[gi]) arm_q[gi] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            data_q  <= '0;
        end else if (standby_i) begin
            ready_q <= 1'b0;
        end else begin
            if (done_i && !ready_q) begin
                data_q  <= frame_i;
                ready_q <= !stop_bad_i;
            end else if (rd_data) begin
                ready_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_stat)      rdata_o = {{PAD_W{1'b0}}, err_q, ready_q};
        else if (rd_data) rdata_o = data_q;
    end

    assign ready_o = ready_q;
    assign err_o   = err_q;
    assign data_o  = data_q;

endmodule

// File: rtl/sticky_uart_rx.sv
module sticky_uart_rx
    import rxu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              rx_en_i,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              two_stop_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic              bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);

    logic               rx_s;
    logic               frame_done;
    logic               stop_bad;
    logic               par_bad;
    logic               busy;
    logic [DATA_W-1:0]  frame_data;
    logic               ready_q;
    logic [NUM_ERR-1:0] err_q;
    logic [DATA_W-1:0]  data_q;
    logic               ovr_q;
    logic               fer_q;
    logic               freeze;

    assign ovr_q  = err_q[ERR_OVR];
    assign fer_q  = err_q[ERR_FER];
    assign freeze = ovr_q || fer_q;

    rxu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    rxu_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .rx_en_i    (rx_en_i),
        .freeze_i   (freeze),
        .tick_i     (tick_i),
        .rx_i       (rx_s),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .two_stop_i (two_stop_i),
        .done_o     (frame_done),
        .stop_bad_o (stop_bad),
        .par_bad_o  (par_bad),
        .busy_o     (busy),
        .data_o     (frame_data)
    );

    rxu_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .done_i     (frame_done),
        .frame_i    (frame_data),
        .stop_bad_i (stop_bad),
        .par_bad_i  (par_bad),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .ready_o    (ready_q),
        .err_o      (err_q),
        .data_o     (data_q)
    );

endmodule

// File: rtl/sticky_uart_rx_chk.sv
module sticky_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_i,
    input logic              rx_en_i,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic              bus_addr_i,
    input logic              frame_done,
    input logic              stop_bad,
    input logic              busy,
    input logic              ready_q,
    input logic              ovr_q,
    input logic              fer_q,
    input logic [DATA_W-1:0] data_q
);

    logic stat_wr;
    assign stat_wr = bus_sel_i && bus_wr_i && !bus_addr_i;

    // R7
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && ready_q && !standby_i) |=> (ovr_q && $stable(data_q)));

    // R5
    framing_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !ready_q && stop_bad && !standby_i) |=> (fer_q && !ready_q));

    // R8
    frozen_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovr_q || fer_q) && !busy) |=> !busy);

    // R11
    disabled_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !frame_done);

    // R9
    overrun_clear_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> $past(standby_i || stat_wr));

    // R9
    framing_clear_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fer_q) |-> $past(standby_i || stat_wr));

    // R12
    standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!ovr_q && !fer_q && !ready_q));

endmodule

bind sticky_uart_rx sticky_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby_i  (standby_i),
    .rx_en_i    (rx_en_i),
    .bus_sel_i  (bus_sel_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .frame_done (frame_done),
    .stop_bad   (stop_bad),
    .busy       (busy),
    .ready_q    (ready_q),
    .ovr_q      (ovr_q),
    .fer_q      (fer_q),
    .data_q     (data_q)
);

// File: tb/sticky_uart_rx_bench.sv
module sticky_uart_rx_bench;

    localparam int CLK_P = 10;
    localparam int BIT_CYC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       rx_en = 1'b1;
    logic       tick = 1'b1;
    logic       rx = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    sticky_uart_rx u_sticky_uart_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby),
        .rx_en_i     (rx_en),
        .tick_i      (tick),
        .rx_i        (rx),
        .par_en_i    (par_en),
        .par_odd_i   (par_odd),
        .two_stop_i  (two_stop),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%02h expected=0x%02h", req, got, exp);
        end
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #(CLK_P/4);
        v = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic expect_reg(input logic a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rx = v;
        repeat (BIT_CYC - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic flip_par,
                              input logic stop1, input logic stop2);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        if (par_en) drive_bit((par_odd ? ~(^b) : (^b)) ^ flip_par);
        drive_bit(stop1);
        if (two_stop) drive_bit(stop2);
        @(negedge clk);
        rx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_standby();
        @(negedge clk);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
    endtask

    task automatic t_reset();
        expect_reg(1'b0, 8'h00, "R1 status after reset");
        expect_reg(1'b1, 8'h00, "R1 data after reset");
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b0, 8'h01, "R3 ready after frame");
        expect_reg(1'b1, 8'hA5, "R3 data A5");
        expect_reg(1'b0, 8'h00, "R3 ready cleared by data read");
        send_frame(8'h01, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b1, 8'h01, "R3 LSB-first data 01");
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b0, 8'h01, "R4 even parity good");
        expect_reg(1'b1, 8'h3C, "R4 data 3C");
        par_odd = 1'b1;
        send_frame(8'hC3, 1'b1, 1'b1, 1'b1);
        expect_reg(1'b0, 8'h09, "R4 odd parity mismatch");
        expect_reg(1'b1, 8'hC3, "R4 data still loaded");
        expect_reg(1'b0, 8'h08, "R10 parity flag survives data read");
        bus_write(1'b0, 8'h00);
        expect_reg(1'b0, 8'h00, "R9 parity flag cleared after read then write 0");
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_false_start();
        @(negedge clk);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        expect_reg(1'b0, 8'h00, "R2 short low pulse gives no frame");
        send_frame(8'h5A, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b1, 8'h5A, "R2 next real frame accepted");
    endtask

    task automatic t_framing();
        send_frame(8'h77, 1'b0, 1'b0, 1'b1);
        expect_reg(1'b0, 8'h04, "R5 framing flag, ready low");
        expect_reg(1'b1, 8'h77, "R5 data loaded on framing error");
        send_frame(8'h11, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b1, 8'h77, "R8 frame ignored while framing flag set");
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        expect_reg(1'b0, 8'h04, "R11 framing flag kept with enable low");
        rx_en = 1'b1;
        bus_write(1'b0, 8'hFF);
        bus_write(1'b0, 8'h00);
        expect_reg(1'b0, 8'h04, "R9 write 0 without armed read ignored");
        bus_write(1'b0, 8'h00);
        expect_reg(1'b0, 8'h00, "R9 framing flag cleared");
        send_frame(8'h22, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b0, 8'h01, "R8 reception resumes after clear");
        expect_reg(1'b1, 8'h22, "R8 resumed data");
    endtask

    task automatic t_overrun();
        send_frame(8'h81, 1'b0, 1'b1, 1'b1);
        send_frame(8'h42, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b0, 8'h03, "R7 overrun flag with ready");
        expect_reg(1'b1, 8'h81, "R7 earlier byte kept");
        expect_reg(1'b0, 8'h02, "R10 overrun survives data read");
        send_frame(8'h99, 1'b0, 1'b1, 1'b1);
        expect_reg(1'b0, 8'h02, "R8 no frame while overrun set");
        expect_reg(1'b1, 8'h81, "R8 data unchanged while overrun set");
        pulse_standby();
        expect_reg(1'b0, 8'h00, "R12 standby clears flags");
    endtask

    task automatic t_rx_disable();
        rx_en = 1'b0;
        send_frame(8'h66, 1'b0, 1'b1, 1'b1);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        expect_reg(1'b0, 8'h00, "R11 no frame with enable low");
        expect_reg(1'b1, 8'h81, "R11 data unchanged with enable low");
    endtask

    task automatic t_two_stop();
        two_stop = 1'b1;
        send_frame(8'h5C, 1'b0, 1'b1, 1'b0);
        expect_reg(1'b0, 8'h01, "R6 bad second stop not flagged");
        expect_reg(1'b1, 8'h5C, "R6 data 5C");
        two_stop = 1'b0;
    endtask

    task automatic t_both_errors();
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'hE7, 1'b1, 1'b0, 1'b1);
        expect_reg(1'b0, 8'h0C, "R13 framing and parity both set");
        bus_write(1'b0, 8'h00);
        expect_reg(1'b0, 8'h00, "R13 both flags cleared");
        par_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_parity();
        t_false_start();
        t_framing();
        t_overrun();
        t_rx_disable();
        t_two_stop();
        t_both_errors();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule